// File: doc/BRIEF.md
# Shared-Pin GPIO Port Controller

This block controls a port of general-purpose pins. Each pin can be driven by a simple register interface, by an alternate digital peripheral, or by an analog function. The block holds five per-pin registers: output data, direction, pull-up enable, slew-rate enable and high-drive select. It decides, pin by pin, who owns the output buffer, whether the input buffer is on, and what a read of the data register returns. The three pad-control registers have no effect inside the block and go straight to the pad.

The peripheral and analog enables and the peripheral's output enable and output value arrive as plain input ports. Ownership has a fixed priority: analog first, then the alternate digital function, then the GPIO function. The direction bit always selects the read-back source. With direction 1 a read returns the output latch. With direction 0 it returns the pin level after a two-flop synchronizer, or zero if that pin's input buffer is off. A parameter mask marks pins as output-only. Such a pin has no input buffer, and its output buffer stays on while the GPIO function owns it.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset all five registers read as 0, the pull, slew and drive outputs are 0, and `pad_oe` equals the output-only mask (default 8'h80, so bit 7 only). `pad_ie` is the inverse of that mask.
- R2: Register offsets are: 0 data, 1 direction, 2 pull-up enable, 3 slew enable, 4 high drive. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both 1. A read with `bus_sel`=1 and `bus_wr`=0 puts the value on `bus_rdata` after that edge. The pull, slew and drive registers drive `pad_pull_en`, `pad_slew_en` and `pad_drive_hi` directly.
- R3: For a pin with no alternate or analog enable, `pad_oe` equals its direction bit (or 1 if the pin is output-only), and `pad_out` equals the data latch.
- R4: A data-register read returns the data latch for every bit whose direction bit is 1, whatever mode the pin is in.
- R5: A data-register read returns the synchronized `pad_in` level for every bit whose direction bit is 0 and whose input buffer is on. A pin change shows up in a read issued two clock edges after the change.
- R6: When `alt_en` is 1 and `ana_en` is 0 for a pin, `pad_oe` and `pad_out` follow `alt_oe` and `alt_out`. The read-back source still follows the direction bit.
- R7: When `ana_en` is 1 for a pin, its `pad_oe`, `pad_out` and `pad_ie` are 0, even if `alt_en` is also 1. A read of that bit returns 0 when its direction bit is 0.
- R8: A data-register write always updates the latch, even while a peripheral or analog function owns the pin. The new value appears on `pad_out` once the GPIO function owns the pin again.
- R9: An output-only pin has `pad_ie`=0. A read of that bit returns 0 while its direction bit is 0 and returns the latch while its direction bit is 1.
- R10: Offsets 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| alt_en | input | 8 | Alternate digital function enable per pin |
| alt_oe | input | 8 | Alternate function output enable |
| alt_out | input | 8 | Alternate function output value |
| ana_en | input | 8 | Analog function enable per pin |
| pad_in | input | 8 | Pin level from the pad |
| pad_oe | output | 8 | Output buffer enable |
| pad_out | output | 8 | Output buffer value |
| pad_ie | output | 8 | Input buffer enable |
| pad_pull_en | output | 8 | Pull-up enable to pad |
| pad_slew_en | output | 8 | Slew-rate control enable to pad |
| pad_drive_hi | output | 8 | High drive strength select to pad |

## Verification
Pad ownership outputs (`pad_oe`, `pad_out`, `pad_ie`) are combinational from the enables and registers. They are checked shortly after the inputs change, or one edge after a register write. Register reads are due one edge after the access. The bench records every issued read in a flag at that edge, and a monitor compares the result against the queued expectation on the next falling edge. Pin-level reads go through the two-flop synchronizer, so the bench waits three edges after changing `pad_in` before it issues the read.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_DATA  = 3'd0,
      REG_DIR   = 3'd1,
      REG_PULL  = 3'd2,
      REG_SLEW  = 3'd3,
      REG_DRIVE = 3'd4
   } reg_ofs_e;

   typedef enum logic [1:0] {
      OWN_GPIO   = 2'd0,
      OWN_ALT    = 2'd1,
      OWN_ANALOG = 2'd2
   } pin_owner_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
   import gpio_port_pkg::*;
#(
   parameter bit OUT_ONLY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_bit,
   input  logic data_bit,
   input  logic alt_en,
   input  logic alt_oe,
   input  logic alt_out,
   input  logic ana_en,
   input  logic sync_in,
   output logic pad_oe,
   output logic pad_out,
   output logic pad_ie,
   output logic rd_bit
);
   pin_owner_e owner;
   logic       gpio_oe;

   always_comb begin
      if (ana_en)      owner = OWN_ANALOG;
      else if (alt_en) owner = OWN_ALT;
      else             owner = OWN_GPIO;
   end

   if (OUT_ONLY) begin : g_out_only
      assign gpio_oe = 1'b1;
      assign pad_ie  = 1'b0;
   end else begin : g_bidir
      assign gpio_oe = dir_bit;
      assign pad_ie  = !ana_en;
   end

   always_comb begin
      unique case (owner)
         OWN_ANALOG: begin pad_oe = 1'b0;   pad_out = 1'b0;     end
         OWN_ALT:    begin pad_oe = alt_oe; pad_out = alt_out;  end
         default:    begin pad_oe = gpio_oe; pad_out = data_bit; end
      endcase
   end

   assign rd_bit = dir_bit ? data_bit : (pad_ie & sync_in);

   AST_ANALOG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ana_en |-> (!pad_oe && !pad_ie && !pad_out)); // R7
   AST_ALT_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
      (alt_en && !ana_en) |-> (pad_oe == alt_oe && pad_out == alt_out)); // R6
   AST_GPIO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!alt_en && !ana_en) |-> (pad_out == data_bit)); // R3
   AST_DIR_READ: assert property (@(posedge clk) disable iff (!rst_n)
      dir_bit |-> (rd_bit == data_bit)); // R4
   AST_OUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (OUT_ONLY && !alt_en && !ana_en) |-> (pad_oe && !pad_ie)); // R9
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   input  logic [WIDTH-1:0]  data_view,
   output logic [WIDTH-1:0]  bus_rdata,
   output logic [WIDTH-1:0]  data_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  pull_q,
   output logic [WIDTH-1:0]  slew_q,
   output logic [WIDTH-1:0]  drive_q
);
   logic             wr_stb, rd_stb;
   logic [WIDTH-1:0] rd_mux;

   assign wr_stb = bus_sel &&  bus_wr;
   assign rd_stb = bus_sel && !bus_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         dir_q   <= '0;
         pull_q  <= '0;
         slew_q  <= '0;
         drive_q <= '0;
      end else if (wr_stb) begin
         case (bus_addr)
            REG_DATA:  data_q  <= bus_wdata;
            REG_DIR:   dir_q   <= bus_wdata;
            REG_PULL:  pull_q  <= bus_wdata;
            REG_SLEW:  slew_q  <= bus_wdata;
            REG_DRIVE: drive_q <= bus_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (bus_addr)
         REG_DATA:  rd_mux = data_view;
         REG_DIR:   rd_mux = dir_q;
         REG_PULL:  rd_mux = pull_q;
         REG_SLEW:  rd_mux = slew_q;
         REG_DRIVE: rd_mux = drive_q;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_stb) bus_rdata <= rd_mux;
   end

   AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && bus_addr == REG_DATA) |=> (data_q == $past(bus_wdata))); // R8
   AST_HOLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && bus_addr > REG_DRIVE) |=> ($stable(data_q) && $stable(dir_q)
         && $stable(pull_q) && $stable(slew_q) && $stable(drive_q))); // R10
   AST_HOLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && bus_addr > REG_DRIVE) |=> (bus_rdata == '0)); // R10
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int unsigned       WIDTH         = 8,
   parameter int unsigned       SYNC_STAGES   = 2,
   parameter logic [WIDTH-1:0]  OUT_ONLY_MASK = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  alt_en,
   input  logic [WIDTH-1:0]  alt_oe,
   input  logic [WIDTH-1:0]  alt_out,
   input  logic [WIDTH-1:0]  ana_en,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_ie,
   output logic [WIDTH-1:0]  pad_pull_en,
   output logic [WIDTH-1:0]  pad_slew_en,
   output logic [WIDTH-1:0]  pad_drive_hi
);
   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("gpio_port_ctrl: WIDTH must be 1..32");
   end

   logic [WIDTH-1:0] data_q, dir_q, sync_in, rd_view;

   gpio_regfile #(.WIDTH(WIDTH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .data_view (rd_view),
      .bus_rdata (bus_rdata),
      .data_q    (data_q),
      .dir_q     (dir_q),
      .pull_q    (pad_pull_en),
      .slew_q    (pad_slew_en),
      .drive_q   (pad_drive_hi)
   );

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (sync_in)
   );

   for (genvar i = 0; i < int'(WIDTH); i++) begin : g_pin
      gpio_pin_mux #(.OUT_ONLY(OUT_ONLY_MASK[i])) u_pin (
         .clk      (clk),
         .rst_n    (rst_n),
         .dir_bit  (dir_q[i]),
         .data_bit (data_q[i]),
         .alt_en   (alt_en[i]),
         .alt_oe   (alt_oe[i]),
         .alt_out  (alt_out[i]),
         .ana_en   (ana_en[i]),
         .sync_in  (sync_in[i]),
         .pad_oe   (pad_oe[i]),
         .pad_out  (pad_out[i]),
         .pad_ie   (pad_ie[i]),
         .rd_bit   (rd_view[i])
      );
   end

   AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == REG_DATA)
      |=> ((bus_rdata & ~$past(dir_q) & ~$past(pad_ie)) == '0)); // R7
   AST_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == REG_DATA)
      |=> ((bus_rdata & $past(dir_q)) == ($past(data_q) & $past(dir_q)))); // R4
endmodule

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic [7:0] alt_en = '0, alt_oe = '0, alt_out = '0, ana_en = '0, pad_in = '0;
   logic [7:0] pad_oe, pad_out, pad_ie, pad_pull_en, pad_slew_en, pad_drive_hi;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_issued = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_port_ctrl i_gpio_port_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out), .ana_en(ana_en),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_ie(pad_ie),
      .pad_pull_en(pad_pull_en), .pad_slew_en(pad_slew_en),
      .pad_drive_hi(pad_drive_hi)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      @(negedge clk);
   endtask

   always @(posedge clk) rd_issued <= rst_n && bus_sel && !bus_wr;

   always @(negedge clk) begin
      if (rd_issued) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: read result with no expectation, actual %02h expected none", bus_rdata);
         end else begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic settle();
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pad_oe", pad_oe, 8'h80);
      check("R1 pad_ie", pad_ie, 8'h7F);
      check("R1 pull", pad_pull_en, 8'h00);
      check("R1 slew", pad_slew_en, 8'h00);
      check("R1 drive", pad_drive_hi, 8'h00);
      bus_read(3'd0, 8'h00, "R1 data");
      bus_read(3'd1, 8'h00, "R1 dir");
      bus_read(3'd4, 8'h00, "R1 drive reg");

      // R3 GPIO output drive
      pad_in = 8'h30;
      bus_write(3'd1, 8'h0F);
      bus_write(3'd0, 8'hA5);
      settle();
      check("R3 pad_oe", pad_oe, 8'h8F);
      check("R3 pad_out", pad_out, 8'hA5);
      @(negedge clk);
      // R4 latch bits + R5 synchronized input bits
      bus_read(3'd0, 8'h35, "R4 R5 mixed read");

      // R2 pad-control registers
      bus_write(3'd2, 8'h3C);
      bus_write(3'd3, 8'hC3);
      bus_write(3'd4, 8'h5A);
      settle();
      check("R2 pull out", pad_pull_en, 8'h3C);
      check("R2 slew out", pad_slew_en, 8'hC3);
      check("R2 drive out", pad_drive_hi, 8'h5A);
      bus_read(3'd2, 8'h3C, "R2 pull reg");
      bus_read(3'd3, 8'hC3, "R2 slew reg");
      bus_read(3'd1, 8'h0F, "R2 dir reg");

      // R5 pin change after synchronizer
      pad_in = 8'h50;
      repeat (3) @(negedge clk);
      bus_read(3'd0, 8'h55, "R5 input change");

      // R6 alternate function ownership
      alt_en = 8'h03; alt_oe = 8'h01; alt_out = 8'h02;
      settle();
      check("R6 pad_oe", pad_oe, 8'h8D);
      check("R6 pad_out", pad_out, 8'hA6);
      @(negedge clk);
      bus_read(3'd0, 8'h55, "R6 read source follows dir");

      // R7 analog wins over alternate and disables buffers
      ana_en = 8'h11;
      settle();
      check("R7 pad_oe", pad_oe, 8'h8C);
      check("R7 pad_ie", pad_ie, 8'h6E);
      @(negedge clk);
      bus_read(3'd0, 8'h45, "R7 analog input reads zero");

      // R8 data write while pins are owned elsewhere
      bus_write(3'd0, 8'hFF);
      settle();
      check("R8 pad_out while owned", pad_out, 8'hEE);
      @(negedge clk);
      alt_en = '0; ana_en = '0;
      settle();
      check("R8 pad_out after release", pad_out, 8'hFF);
      check("R8 pad_oe after release", pad_oe, 8'h8F);
      @(negedge clk);

      // R9 output-only pin
      pad_in = 8'h80;
      repeat (3) @(negedge clk);
      bus_read(3'd0, 8'h0F, "R9 output-only reads zero");
      bus_write(3'd1, 8'h8F);
      settle();
      check("R9 pad_ie", pad_ie, 8'h7F);
      @(negedge clk);
      bus_read(3'd0, 8'h8F, "R9 output-only reads latch");

      // R10 unused offsets
      bus_write(3'd5, 8'hFF);
      bus_write(3'd7, 8'h00);
      bus_read(3'd5, 8'h00, "R10 offset 5");
      bus_read(3'd6, 8'h00, "R10 offset 6");
      bus_read(3'd1, 8'h8F, "R10 dir unchanged");
      bus_read(3'd4, 8'h5A, "R10 drive unchanged");
      settle();
      check("R10 pull unchanged", pad_pull_en, 8'h3C);

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule